// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a short burst of up to four accesses from one starting address. On a load cycle with the part selected, it captures the full start address and the access type (read or write). Each later advance cycle steps only the two lowest address bits. Those bits follow either a wrapping increment or an XOR interleave, and a single order pin picks which. The upper address bits never move during a burst.

A load cycle with the part not selected ends the burst. After that, advance cycles have no effect until a new load arrives. A stall input freezes all state. All outputs are registered, so a control cycle sampled at one rising edge appears on the outputs right after that edge.

Top module: `bseq_top`

## Requirements
- R1: With `stall_i`=0, `adv_i`=0 and `sel_i`=1 at a rising edge, the outputs after that edge are `addr_o`=`addr_i`, `wr_o`=`wr_i` and `active_o`=1.
- R2: While a burst is active, advance cycles keep `addr_o` bits above bit 1 unchanged. Bits 1:0 wrap within the group of four, so the fifth address of a burst equals the first.
- R3: With `order_i`=0 (linear), the n-th advance of a burst gives bits 1:0 = (start bits + n) mod 4. For example, start 1 gives 1,2,3,0.
- R4: With `order_i`=1 (interleaved), the n-th advance gives bits 1:0 = start bits XOR n. For example, start 1 gives 1,0,3,2.
- R5: An advance cycle (`adv_i`=1) ignores `sel_i` and `wr_i`. `wr_o` keeps the value captured at the load for the whole burst.
- R6: A load cycle with `sel_i`=0 drives `active_o` to 0 and leaves `addr_o` and `wr_o` as they were. Later advance cycles leave all outputs unchanged until a selected load.
- R7: With `stall_i`=1 at an edge, no output changes, whatever the other inputs are.
- R8: Synchronous active-high `rst` sets `addr_o` to 0, `wr_o` to 0 and `active_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | 1 = ignore this edge, hold all state |
| adv_i | input | 1 | 0 = load/deselect cycle, 1 = advance cycle |
| sel_i | input | 1 | 1 = all chip selects active (only used on load) |
| wr_i | input | 1 | Access type on load: 1 = write, 0 = read |
| order_i | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | Start address, captured on a selected load |
| addr_o | output | ADDR_W | Current access address |
| wr_o | output | 1 | Access type latched for the burst |
| active_o | output | 1 | 1 = a burst is in progress |

## Verification
On every cycle, assertions check the load capture, the frozen upper address bits during advances, the held access type, the stall freeze and the idle behaviour after a deselect. The exact low-bit orders depend on the start value and the mode, so only the bench's scenarios can show them. These scenarios cover a linear run with wrap, an interleaved run, a mid-burst stall, and a reset in the middle of a burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] step_i,
  input  order_e             order_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_w;
  logic [BURST_W-1:0] ilv_w;

  // wrapping sum stays inside the burst group by width truncation
  assign lin_w = start_i + step_i;
  assign ilv_w = start_i ^ step_i;

  always_comb begin
    case (order_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_nxt_o,
  output logic [BURST_W-1:0] step_nxt_o,
  output logic              upd_o,
  output logic              wr_o,
  output logic              active_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;
  logic               wr_q;
  logic               act_q;
  logic               wr_n;
  logic               act_n;

  always_comb begin
    base_nxt_o = base_q;
    step_nxt_o = step_q;
    wr_n       = wr_q;
    act_n      = act_q;
    upd_o      = 1'b0;
    if (!stall_i) begin
      if (!adv_i) begin
        if (sel_i) begin
          base_nxt_o = addr_i;
          step_nxt_o = '0;
          wr_n       = wr_i;
          act_n      = 1'b1;
          upd_o      = 1'b1;
        end else begin
          act_n = 1'b0;
        end
      end else if (act_q) begin
        step_nxt_o = step_q + 1'b1;
        upd_o      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
      wr_q   <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_nxt_o;
      step_q <= step_nxt_o;
      wr_q   <= wr_n;
      act_q  <= act_n;
    end
  end

  assign wr_o     = wr_q;
  assign active_o = act_q;

  AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && adv_i) |=> (wr_o == $past(wr_o))); // R5
endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              active_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_nxt;
  logic [BURST_W-1:0] step_nxt;
  logic [BURST_W-1:0] low_nxt;
  logic               upd;
  logic [ADDR_W-1:0]  addr_q;
  order_e             ord;

  assign ord = order_e'(order_i);

  bseq_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .stall_i    (stall_i),
    .adv_i      (adv_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .base_nxt_o (base_nxt),
    .step_nxt_o (step_nxt),
    .upd_o      (upd),
    .wr_o       (wr_o),
    .active_o   (active_o)
  );

  bseq_order #(.BURST_W(BURST_W)) order_i0 (
    .start_i (base_nxt[BURST_W-1:0]),
    .step_i  (step_nxt),
    .order_i (ord),
    .low_o   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (upd) begin
      addr_q <= {base_nxt[ADDR_W-1:BURST_W], low_nxt};
    end
  end

  assign addr_o = addr_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !adv_i && sel_i) |=> (addr_o == $past(addr_i) && active_o)); // R1
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && adv_i && active_o) |=>
      (addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]))); // R2
  AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && adv_i && !active_o) |=> (!active_o && $stable(addr_o))); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(addr_o) && $stable(wr_o) && $stable(active_o))); // R7

  initial begin
    AST_HI_WIDTH: assert (HI_W >= 0); // R2
  end
endmodule

// File: tb/bseq_top_tb_top.sv
`timescale 1ns/1ps
module bseq_top_tb_top;
  localparam int AW = 8;

  typedef struct packed {
    logic          stall;
    logic          adv;
    logic          sel;
    logic          wr;
    logic          ord;
    logic [AW-1:0] addr;
    logic [AW-1:0] e_addr;
    logic          e_wr;
    logic          e_act;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'hA5, 8'hA5,1'b0,1'b1,4'd1}, // R1 linear load
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h00, 8'hA6,1'b0,1'b1,4'd5}, // R5 sel/wr ignored
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00, 8'hA7,1'b0,1'b1,4'd3}, // R3
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00, 8'hA4,1'b0,1'b1,4'd2}, // R2 wrap
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00, 8'hA5,1'b0,1'b1,4'd2}, // R2 back to start
    '{1'b0,1'b0,1'b1,1'b1,1'b1,8'h3D, 8'h3D,1'b1,1'b1,4'd1}, // R1 write load
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h00, 8'h3C,1'b1,1'b1,4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h00, 8'h3F,1'b1,1'b1,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h00, 8'h3E,1'b1,1'b1,4'd5}, // R5
    '{1'b1,1'b1,1'b1,1'b0,1'b0,8'hFF, 8'h3E,1'b1,1'b1,4'd7}, // R7 stall advance
    '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h3E,1'b1,1'b1,4'd7}, // R7 stall load
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h77, 8'h3E,1'b1,1'b0,4'd6}, // R6 deselect
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 8'h3E,1'b1,1'b0,4'd6}, // R6
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'h55, 8'h3E,1'b1,1'b0,4'd6}, // R6 adv with sel
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h12, 8'h12,1'b0,1'b1,4'd1}, // R1 reload
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h00, 8'h13,1'b0,1'b1,4'd3}, // R3
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h00, 8'h10,1'b0,1'b1,4'd3}  // R3 wrap
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall_i = 1'b0, adv_i = 1'b0, sel_i = 1'b0, wr_i = 1'b0, order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic          wr_o, active_o;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  bseq_top #(.ADDR_W(AW), .BURST_W(2)) dut_i (
    .clk(clk), .rst(rst), .stall_i(stall_i), .adv_i(adv_i), .sel_i(sel_i),
    .wr_i(wr_i), .order_i(order_i), .addr_i(addr_i),
    .addr_o(addr_o), .wr_o(wr_o), .active_o(active_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic ew, input logic eact);
    n_chk++;
    if (addr_o !== ea || wr_o !== ew || active_o !== eact) begin
      n_bad++;
      $display("FAIL %s: got addr=%h wr=%b act=%b, expected addr=%h wr=%b act=%b",
               tag, addr_o, wr_o, active_o, ea, ew, eact);
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 reset state", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      stall_i = VECS[i].stall;
      adv_i   = VECS[i].adv;
      sel_i   = VECS[i].sel;
      wr_i    = VECS[i].wr;
      order_i = VECS[i].ord;
      addr_i  = VECS[i].addr;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].e_addr, VECS[i].e_wr, VECS[i].e_act);
    end

    // R4 interleaved from start 2: 2,3,0,1 then wrap back to 2
    stall_i = 1'b0; adv_i = 1'b0; sel_i = 1'b1; wr_i = 1'b1; order_i = 1'b1; addr_i = 8'hC6;
    @(posedge clk); @(negedge clk);
    check("R4 load C6", 8'hC6, 1'b1, 1'b1);
    adv_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 step1", 8'hC7, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R4 step2", 8'hC4, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R4 step3", 8'hC5, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R2 interleave wrap", 8'hC6, 1'b1, 1'b1);

    // R8 reset in mid burst
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 mid-burst reset", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 advance after reset idle", 8'h00, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule